// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a VCO-rate clock down to one feedback pulse per comparison period. The integer ratio comes from a dual-modulus prescaler, modelled as a digital divide-by-P or divide-by-(P+1) counter, that is steered by a swallow counter and a main counter. A small fractional accumulator sits on top of this. Each time it wraps, the current divide cycle is stretched by exactly one VCO period. Over many cycles the average ratio therefore lands between integers.

The block runs entirely in the VCO clock domain. The swallow count, main count, fractional numerator, prescaler select and modulus select are plain level inputs. They are captured together at the boundary between divide cycles. A hold input stands for the counter-reset and power-down controls: it clears the counters and the accumulator. A status pin reports whether the settings on the inputs are illegal. The block carries no streaming data, so there is no valid/ready handshake. Every pin is an ordinary level, and the feedback output is a single-cycle strobe.

Top module: `fracn_feedback_divider`

## Requirements
- R1: With a zero numerator, consecutive feedback pulses are exactly P*B + A VCO cycles apart. P is 16 when `presc_hi`=0 and 32 when `presc_hi`=1.
- R2: With `frac_mod16`=1, the accumulator adds the numerator once per divide cycle. When the sum reaches 16, that cycle is one VCO period longer and the accumulator keeps the sum minus 16. Over 16 cycles exactly F cycles are long.
- R3: With `frac_mod16`=0, the same rule applies with a wrap value of 15. Over 15 cycles exactly F cycles are long.
- R4: `cfg_illegal` is high whenever B < 3 or B < A + 2. A new divide cycle never starts with such a setting, so no pulses appear.
- R5: A numerator of 15 with `frac_mod16`=0 raises `cfg_illegal` and is never used. The same numerator with `frac_mod16`=1 is legal.
- R6: While `rst` or `hold` is high, no pulse is produced and the counters and accumulator clear. The first pulse comes N+1 clock edges after the release, where N is computed from a cleared accumulator.
- R7: `fb_pulse` is high for exactly one VCO clock per divide cycle.
- R8: Input values are captured as a set only at the edge that ends a divide cycle, or at the start after a hold or an illegal setting. A change in the middle of a cycle affects only the following cycle.
- R9: The boundary settings B = A + 2 (including A=31) and B = 3 divide exactly as R1 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Counter reset / power down, active high |
| a_val | input | 5 | Swallow count A |
| b_val | input | 10 | Main count B |
| frac_num | input | 4 | Fractional numerator F |
| presc_hi | input | 1 | Prescaler select: 0 gives 16/17, 1 gives 32/33 |
| frac_mod16 | input | 1 | Accumulator wrap: 1 gives 16, 0 gives 15 |
| fb_pulse | output | 1 | One-cycle feedback strobe at the end of each divide cycle |
| cfg_illegal | output | 1 | Current inputs break a divide rule |

## Verification
Two things can fall on the same clock edge: the end of a divide cycle, which also reloads the counters and steps the accumulator, and a change of the programmed inputs or of hold. The bench changes the settings in the very cycle a pulse is seen, and also part way through a period. It then judges the captured set by the length of the next two intervals, which are compared with a bench model of the accumulator. Hold is raised in the middle of a period. The restart interval then shows whether the accumulator state was cleared rather than carried across.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int A_W = 5;
  localparam int B_W = 10;
  localparam int F_W = 4;

  typedef struct packed {
    logic           p_hi;
    logic           mod_full;
    logic [F_W-1:0] num;
    logic [B_W-1:0] b;
    logic [A_W-1:0] a;
  } div_cfg_t;
endpackage

// File: rtl/fracn_cfg_check.sv
module fracn_cfg_check
  import fracn_pkg::*;
(
  input  div_cfg_t cfg,
  output logic     illegal
);
  logic [B_W:0] a_plus2;
  logic         b_small, b_vs_a, num_bad;

  always_comb begin
    a_plus2 = (B_W+1)'(cfg.a) + (B_W+1)'(2);
    b_small = cfg.b < B_W'(3);
    b_vs_a  = {1'b0, cfg.b} < a_plus2;
    num_bad = !cfg.mod_full && (cfg.num == {F_W{1'b1}});
    illegal = b_small || b_vs_a || num_bad;
  end
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           mod_full,
  input  logic [F_W-1:0] num,
  output logic           carry
);
  localparam int SW = F_W + 1;

  logic [F_W-1:0] acc_q, acc_next;
  logic [SW-1:0]  sum, modv;
  logic           last_full;

  always_comb begin
    modv     = mod_full ? SW'(2**F_W) : SW'(2**F_W - 1);
    sum      = {1'b0, acc_q} + {1'b0, num};
    carry    = sum >= modv;
    acc_next = carry ? F_W'(sum - modv) : sum[F_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q     <= '0;
      last_full <= 1'b1;
    end else if (step) begin
      acc_q     <= acc_next;
      last_full <= mod_full;
    end
  end

  // R3
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    !last_full |-> (acc_q != {F_W{1'b1}}));

  // R6
  acc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/fracn_swallow_core.sv
module fracn_swallow_core
  import fracn_pkg::*;
#(
  parameter int P_LO = 16,
  parameter int P_HI = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           illegal,
  input  logic           carry,
  input  logic           p_hi,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           load,
  output logic           pulse
);
  localparam int PC_W = $clog2(P_HI + 1);
  localparam int AR_W = A_W + 1;

  logic            running;
  logic [PC_W-1:0] pc;
  logic [AR_W-1:0] a_rem, a_eff, a_dec;
  logic [B_W-1:0]  b_rem;
  logic            p_hi_q;
  logic            pre_end;

  function automatic logic [PC_W-1:0] pc_start(input logic hi, input logic swallow);
    int base;
    base = hi ? P_HI : P_LO;
    return swallow ? PC_W'(base) : PC_W'(base - 1);
  endfunction

  always_comb begin
    pre_end = running && (pc == '0) && (b_rem == B_W'(1));
    load    = !hold && !illegal && (!running || pre_end);
    a_eff   = AR_W'(a_in) + AR_W'(carry);
    a_dec   = (a_rem != '0) ? a_rem - AR_W'(1) : a_rem;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      running <= 1'b0;
      pc      <= '0;
      a_rem   <= '0;
      b_rem   <= '0;
      p_hi_q  <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= pre_end;
      if (load) begin
        running <= 1'b1;
        a_rem   <= a_eff;
        b_rem   <= b_in;
        p_hi_q  <= p_hi;
        pc      <= pc_start(p_hi, a_eff != '0);
      end else if (pre_end) begin
        running <= 1'b0;
      end else if (running) begin
        if (pc == '0) begin
          a_rem <= a_dec;
          b_rem <= b_rem - B_W'(1);
          pc    <= pc_start(p_hi_q, a_dec != '0);
        end else begin
          pc <= pc - PC_W'(1);
        end
      end
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R1
  swallow_lt_main_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> ({{(B_W-AR_W){1'b0}}, a_rem} < b_rem));

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!pulse && !running));

  // R4
  illegal_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && illegal) |=> !running);
endmodule

// File: rtl/fracn_feedback_divider.sv
module fracn_feedback_divider
  import fracn_pkg::*;
#(
  parameter int P_LO = 16,
  parameter int P_HI = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic [F_W-1:0] frac_num,
  input  logic           presc_hi,
  input  logic           frac_mod16,
  output logic           fb_pulse,
  output logic           cfg_illegal
);
  div_cfg_t cfg;
  logic     carry, load;

  assign cfg = '{p_hi: presc_hi, mod_full: frac_mod16, num: frac_num, b: b_val, a: a_val};

  fracn_cfg_check u_check (
    .cfg     (cfg),
    .illegal (cfg_illegal)
  );

  fracn_accum u_accum (
    .clk      (clk),
    .rst      (rst),
    .clr      (hold),
    .step     (load),
    .mod_full (cfg.mod_full),
    .num      (cfg.num),
    .carry    (carry)
  );

  fracn_swallow_core #(.P_LO(P_LO), .P_HI(P_HI)) u_core (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .illegal (cfg_illegal),
    .carry   (carry),
    .p_hi    (cfg.p_hi),
    .a_in    (cfg.a),
    .b_in    (cfg.b),
    .load    (load),
    .pulse   (fb_pulse)
  );
endmodule

// File: tb/fracn_feedback_divider_tb.sv
module fracn_feedback_divider_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [4:0] a_val = 5'd5;
  logic [9:0] b_val = 10'd10;
  logic [3:0] frac_num = 4'd0;
  logic       presc_hi = 1'b0;
  logic       frac_mod16 = 1'b1;
  logic       fb_pulse, cfg_illegal;

  int n_chk = 0, n_bad = 0, cyc = 0, m_acc = 0, nxt_exp = 0;
  int pa, pb, pn;
  logic pp, pm;

  fracn_feedback_divider u_dut (
    .clk(clk), .rst(rst), .hold(hold), .a_val(a_val), .b_val(b_val),
    .frac_num(frac_num), .presc_hi(presc_hi), .frac_mod16(frac_mod16),
    .fb_pulse(fb_pulse), .cfg_illegal(cfg_illegal)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog (R1..R9 run) actual=%0d cycles expected<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int base_period();
    return (presc_hi ? 32 : 16) * int'(b_val) + int'(a_val);
  endfunction

  function automatic int model_next();
    int m, s, c;
    m = frac_mod16 ? 16 : 15;
    s = m_acc + int'(frac_num);
    c = (s >= m) ? 1 : 0;
    m_acc = c ? s - m : s;
    return base_period() + c;
  endfunction

  task automatic apply_pending();
    a_val = pa[4:0]; b_val = pb[9:0]; frac_num = pn[3:0];
    presc_hi = pp; frac_mod16 = pm;
  endtask

  task automatic measure(input string tag, input int chg_at, input int k0, output int k);
    k = k0;
    do begin
      @(negedge clk);
      k++;
      if (k == chg_at) apply_pending();
    end while (!fb_pulse);
    check(k == nxt_exp, tag, k, nxt_exp);
    nxt_exp = model_next();
  endtask

  task automatic release_and_first(input string tag);
    int k;
    m_acc = 0;
    @(negedge clk);
    rst = 1'b0; hold = 1'b0;
    nxt_exp = model_next() + 1;
    measure(tag, 0, 0, k);
  endtask

  task automatic set_cfg(input int p, input int a, input int b, input int n, input int m);
    presc_hi = p[0]; a_val = a[4:0]; b_val = b[9:0]; frac_num = n[3:0]; frac_mod16 = m[0];
  endtask

  task automatic no_pulse_window(input string tag, input int len);
    int seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (fb_pulse) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    int k, longs, base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(fb_pulse == 1'b0, "R6 reset state pulse", fb_pulse, 0);

    // R6: restart after reset, then R1 steady periods (P=16)
    set_cfg(0, 5, 10, 0, 1);
    release_and_first("R6 first pulse after reset");
    @(negedge clk);
    check(fb_pulse == 1'b0, "R7 pulse width", fb_pulse, 0);
    measure("R1 P16 period after width check", 0, 1, k);
    for (int i = 0; i < 2; i++) measure("R1 P16 period", 0, 0, k);

    // R1: P=32, change applied in the same cycle as a pulse (R8)
    set_cfg(1, 7, 12, 0, 1);
    measure("R8 old set still used", 0, 0, k);
    for (int i = 0; i < 2; i++) measure("R1 P32 period", 0, 0, k);

    // R9: boundary settings
    set_cfg(1, 31, 33, 0, 1);
    measure("R9 transition", 0, 0, k);
    measure("R9 A=31 B=33", 0, 0, k);
    set_cfg(0, 0, 3, 0, 1);
    measure("R9 transition", 0, 0, k);
    measure("R9 B=3 A=0", 0, 0, k);
    set_cfg(0, 1, 3, 0, 1);
    measure("R9 transition", 0, 0, k);
    measure("R9 B=3 A=1", 0, 0, k);

    // R8: mid-cycle change only affects the following cycle
    pp = 1'b0; pa = 3; pb = 20; pn = 0; pm = 1'b1;
    measure("R8 mid-cycle change ignored", 20, 0, k);
    measure("R8 new set in next cycle", 0, 0, k);

    // R2: modulus 16, F=5
    set_cfg(0, 2, 8, 5, 1);
    measure("R2 transition", 0, 0, k);
    base = base_period(); longs = 0;
    for (int i = 0; i < 16; i++) begin
      measure("R2 mod16 period", 0, 0, k);
      if (k == base + 1) longs++;
    end
    check(longs == 5, "R2 long cycles per 16", longs, 5);

    // R3: modulus 15, F=4
    set_cfg(0, 4, 9, 4, 0);
    measure("R3 transition", 0, 0, k);
    base = base_period(); longs = 0;
    for (int i = 0; i < 15; i++) begin
      measure("R3 mod15 period", 0, 0, k);
      if (k == base + 1) longs++;
    end
    check(longs == 4, "R3 long cycles per 15", longs, 4);

    // R6: hold mid-period clears counters and accumulator
    set_cfg(0, 6, 11, 9, 1);
    repeat (30) @(negedge clk);
    hold = 1'b1;
    no_pulse_window("R6 no pulse during hold", 400);
    release_and_first("R6 first pulse after hold");
    measure("R6 acc restarts from zero", 0, 0, k);
    measure("R6 acc restarts from zero", 0, 0, k);

    // R4: illegal main count
    hold = 1'b1;
    set_cfg(0, 0, 2, 0, 1);
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R4 B<3 flag", cfg_illegal, 1);
    hold = 1'b0;
    no_pulse_window("R4 no pulse with B<3", 300);
    set_cfg(0, 4, 5, 0, 1);
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R4 B<A+2 flag", cfg_illegal, 1);
    no_pulse_window("R4 no pulse with B<A+2", 300);

    // R5: numerator 15 in modulus-15 mode
    set_cfg(0, 4, 6, 15, 0);
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R5 F=15 mod15 flag", cfg_illegal, 1);
    no_pulse_window("R5 no pulse with F=15 mod15", 300);
    set_cfg(0, 4, 6, 15, 1);
    #1;
    check(cfg_illegal == 1'b0, "R5 F=15 mod16 legal", cfg_illegal, 0);
    hold = 1'b1;
    release_and_first("R5 start with F=15 mod16");
    for (int i = 0; i < 3; i++) measure("R5 F=15 mod16 period", 0, 0, k);

    // Random legal settings, applied on pulse cycles or mid-cycle
    for (int i = 0; i < 40; i++) begin
      int r, lo;
      r  = int'($urandom_range(0, 3));
      pp = $urandom_range(0, 3) == 0;
      pa = int'($urandom_range(0, 31));
      lo = (pa + 2 < 3) ? 3 : pa + 2;
      pb = lo + int'($urandom_range(0, 6));
      pm = $urandom_range(0, 1) == 1;
      pn = int'($urandom_range(0, 15));
      if (!pm && pn == 15) pn = 14;
      if (r == 0) begin
        apply_pending();
        measure("R2 random period", 0, 0, k);
      end else if (r == 1) begin
        measure("R8 random mid-cycle", 10, 0, k);
      end else begin
        measure("R1 random period", 0, 0, k);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule